// File: doc/BRIEF.md
# Autonomous Single-Cell Charge Sequencer

This block steps one lithium cell through a complete charge cycle with no help from software. Analog comparators elsewhere on the chip report whether the cell sits below the precharge level, below the recharge level or at the regulation voltage. They also report whether the charge current has fallen under the termination limit, whether each of two thermistors lies inside its window, and whether the die is too hot. The sequencer turns these reports into a phase code for the regulation loops, plus status flags for the rest of the chip.

Every comparator report first crosses into the clock domain through a synchroniser. It then has to hold steady for a programmable number of cycles before the state machine acts on it. Charging is allowed only when a 2-bit mode field selects charging and an active-low enable pin is held low. A separate mode, selected by the other field code together with a high OTG pin, requests boost supply to the USB port. A safety timer limits the time spent in the two bulk phases. When it runs out, the block locks into a fault until it is disabled and enabled again.

Top module: `charge_sequencer`

## Requirements
- R1: After reset, and before charging is permitted, `phase` is 2'b00 and `charging`, `chargeDone`, `suspended`, `foldbackReq` and `faultOut` are all low.
- R2: When charging becomes permitted, the cycle starts in precharge (`phase` = 2'b01) if the filtered below-precharge flag is set, and otherwise in constant current (`phase` = 2'b10).
- R3: The phases advance only forward. Precharge moves to constant current once the below-precharge flag clears. Constant current moves to constant voltage (`phase` = 2'b11) once the at-regulation flag sets.
- R4: In constant voltage, a set below-termination flag ends the cycle. `chargeDone` goes high, `charging` goes low and `phase` returns to 2'b00.
- R5: While done, a set below-recharge flag starts a new cycle. It enters precharge or constant current by the same rule as R2.
- R6: While either thermistor flag reports out of window, an active phase is suspended. `suspended` is high, `charging` is low, and `phase` holds its value. No phase change happens until both flags are back in window, and then charging resumes.
- R7: Charging is permitted only when `modeSel` = 2'b01 and `enableN` = 0. If either condition is lost, the block returns to idle at the next clock edge and `phase` reads 2'b00.
- R8: `boostEn` is high exactly while `modeSel` = 2'b10 and `otgPin` = 1. Charging is off during boost.
- R9: While charging and the junction-hot flag is set, `foldbackReq` is high and the phase carries on unchanged.
- R10: The safety timer counts the unsuspended cycles spent in constant current and constant voltage. After TIMER_TICKS such cycles it latches `faultOut` high and stops charging. The fault clears only when charging stops being permitted and is then permitted again.
- R11: A comparator level that lasts fewer than DEB_CYCLES consecutive synchronised cycles has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| battBelowPre | input | 1 | Cell voltage under the precharge level (async) |
| battBelowRecharge | input | 1 | Cell voltage under the recharge level (async) |
| battAtReg | input | 1 | Cell voltage at the regulation target (async) |
| currBelowTerm | input | 1 | Charge current under the termination limit (async) |
| therm1InWindow | input | 1 | Thermistor 1 inside its window (async) |
| therm2InWindow | input | 1 | Thermistor 2 inside its window (async) |
| junctionHot | input | 1 | Die temperature above its limit (async) |
| enableN | input | 1 | Active-low charge enable pin (synchronous) |
| otgPin | input | 1 | Boost request pin (synchronous) |
| modeSel | input | 2 | Mode field: 01 charge, 10 boost |
| phase | output | 2 | 00 none, 01 precharge, 10 constant current, 11 constant voltage |
| charging | output | 1 | Current is being delivered to the cell |
| chargeDone | output | 1 | Cycle terminated, waiting for recharge level |
| suspended | output | 1 | Active phase held by a thermistor out of window |
| boostEn | output | 1 | Boost supply requested |
| foldbackReq | output | 1 | Request to reduce charge current for die heat |
| faultOut | output | 1 | Safety timer expired, latched |

## Verification
The assertions take it for granted that `enableN`, `otgPin` and `modeSel` are already synchronous to `clk`, because they act on those pins in the very next cycle. The comparator inputs, by contrast, may change at any time. The bench drives every input on the falling edge. Before each check, it lets a comparator change settle for longer than the synchroniser depth plus the debounce window. The glitch case is the one exception: it deliberately holds a level for less than that window. The timer scenario places its checks well clear of either side of the expiry cycle.

// File: rtl/charge_seq_pkg.sv
package charge_seq_pkg;

  localparam int FLAG_COUNT = 7;
  localparam int FL_BELOW_PRE  = 0;
  localparam int FL_BELOW_RECH = 1;
  localparam int FL_AT_REG     = 2;
  localparam int FL_BELOW_TERM = 3;
  localparam int FL_TS1_OK     = 4;
  localparam int FL_TS2_OK     = 5;
  localparam int FL_HOT        = 6;

  localparam logic [1:0] MODE_CHARGE = 2'b01;
  localparam logic [1:0] MODE_BOOST  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_CC, ST_CV, ST_DONE, ST_FAULT
  } seqState_t;

  typedef enum logic [1:0] {
    PH_NONE = 2'b00, PH_PRE = 2'b01, PH_CC = 2'b10, PH_CV = 2'b11
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClear;
    logic timerRun;
  } timerCtl_t;

  // filtered conditions from datapath to control
  typedef struct packed {
    logic belowPre;
    logic belowRech;
    logic atReg;
    logic belowTerm;
    logic ts1Ok;
    logic ts2Ok;
    logic hot;
    logic timerExpired;
  } senseBus_t;

endpackage

// File: rtl/charge_seq_filter.sv
module charge_seq_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cntQ;
  logic                   cleanQ;
  logic                   syncOut;

  assign syncOut  = syncQ[SYNC_STAGES-1];
  assign cleanOut = cleanQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      cleanQ <= 1'b0;
    end else if (syncOut != cleanQ) begin
      if (cntQ == CNT_W'(DEB_CYCLES - 1)) begin
        cleanQ <= syncOut;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end else begin
      cntQ <= '0;
    end
  end

  // R11: the clean level moves only after the synchronised level disagreed with it
  assert_clean_follows_sync_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cleanQ) |-> ($past(syncOut) != $past(cleanQ)));

endmodule

// File: rtl/charge_seq_datapath.sv
module charge_seq_datapath
  import charge_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8,
  parameter int TIMER_TICKS = 100000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FLAG_COUNT-1:0] rawFlags,
  input  timerCtl_t             timerCtl,
  output senseBus_t             sense
);

  localparam int TMR_W = $clog2(TIMER_TICKS + 1);

  logic [FLAG_COUNT-1:0] cleanFlags;
  logic [TMR_W-1:0]      tmrQ;

  for (genvar gi = 0; gi < FLAG_COUNT; gi++) begin : g_filter
    charge_seq_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
    ) i_filter (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawFlags[gi]),
      .cleanOut(cleanFlags[gi])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ <= '0;
    end else if (timerCtl.timerClear) begin
      tmrQ <= '0;
    end else if (timerCtl.timerRun && (tmrQ != TMR_W'(TIMER_TICKS))) begin
      tmrQ <= tmrQ + 1'b1;
    end
  end

  always_comb begin
    sense.belowPre     = cleanFlags[FL_BELOW_PRE];
    sense.belowRech    = cleanFlags[FL_BELOW_RECH];
    sense.atReg        = cleanFlags[FL_AT_REG];
    sense.belowTerm    = cleanFlags[FL_BELOW_TERM];
    sense.ts1Ok        = cleanFlags[FL_TS1_OK];
    sense.ts2Ok        = cleanFlags[FL_TS2_OK];
    sense.hot          = cleanFlags[FL_HOT];
    sense.timerExpired = (tmrQ == TMR_W'(TIMER_TICKS));
  end

  // R10: the timer stands still when the control neither runs nor clears it
  assert_timer_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!timerCtl.timerRun && !timerCtl.timerClear) |=> $stable(tmrQ));

  // R10: a clear strobe always brings the count back to zero
  assert_timer_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    timerCtl.timerClear |=> !sense.timerExpired);

endmodule

// File: rtl/charge_seq_control.sv
module charge_seq_control
  import charge_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableN,
  input  logic       otgPin,
  input  logic [1:0] modeSel,
  input  senseBus_t  sense,
  output timerCtl_t  timerCtl,
  output logic [1:0] phase,
  output logic       charging,
  output logic       chargeDone,
  output logic       suspended,
  output logic       boostEn,
  output logic       foldbackReq,
  output logic       faultOut
);

  seqState_t stateQ, stateNxt;
  logic      chargeOk;
  logic      tempOk;
  logic      activePhase;
  seqState_t entryState;

  assign chargeOk   = (modeSel == MODE_CHARGE) && !enableN;
  assign tempOk     = sense.ts1Ok && sense.ts2Ok;
  assign entryState = sense.belowPre ? ST_PRE : ST_CC;

  always_comb begin
    stateNxt = stateQ;
    if (!chargeOk) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE:  stateNxt = entryState;
        ST_PRE:   if (tempOk && !sense.belowPre) stateNxt = ST_CC;
        ST_CC: begin
          if (tempOk) begin
            if (sense.timerExpired)  stateNxt = ST_FAULT;
            else if (sense.atReg)    stateNxt = ST_CV;
          end
        end
        ST_CV: begin
          if (tempOk) begin
            if (sense.timerExpired)  stateNxt = ST_FAULT;
            else if (sense.belowTerm) stateNxt = ST_DONE;
          end
        end
        ST_DONE:  if (sense.belowRech) stateNxt = entryState;
        ST_FAULT: stateNxt = ST_FAULT;
        default:  stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  assign activePhase = (stateQ == ST_PRE) || (stateQ == ST_CC) || (stateQ == ST_CV);

  always_comb begin
    timerCtl.timerClear = (stateQ == ST_IDLE) || (stateQ == ST_DONE);
    timerCtl.timerRun   = ((stateQ == ST_CC) || (stateQ == ST_CV)) && tempOk;
  end

  always_comb begin
    unique case (stateQ)
      ST_PRE:  phase = PH_PRE;
      ST_CC:   phase = PH_CC;
      ST_CV:   phase = PH_CV;
      default: phase = PH_NONE;
    endcase
  end

  assign charging    = activePhase && tempOk;
  assign suspended   = activePhase && !tempOk;
  assign chargeDone  = (stateQ == ST_DONE);
  assign faultOut    = (stateQ == ST_FAULT);
  assign foldbackReq = charging && sense.hot;
  assign boostEn     = (modeSel == MODE_BOOST) && otgPin;

  // R7: losing the enable condition empties the phase at the next edge
  assert_idle_on_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enableN || (modeSel != 2'b01)) |=> (phase == 2'b00) && !charging);

  // R8: boost request keeps the charger off
  assert_boost_no_charge_R8: assert property (@(posedge clk) disable iff (!rstN)
    boostEn |=> !charging);

  // R3: precharge never jumps past constant current
  assert_pre_forward_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PRE) |=> (stateQ == ST_PRE) || (stateQ == ST_CC) || (stateQ == ST_IDLE));

  // R4: done is only reached from constant voltage
  assert_done_from_cv_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_DONE) && ($past(stateQ) != ST_DONE)) |-> ($past(stateQ) == ST_CV));

  // R6: a suspended phase holds while charging stays permitted
  assert_suspend_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && chargeOk) |=> $stable(phase));

  // R10: timer expiry in a bulk phase ends in fault
  assert_expiry_faults_R10: assert property (@(posedge clk) disable iff (!rstN)
    (chargeOk && tempOk && sense.timerExpired && ((stateQ == ST_CC) || (stateQ == ST_CV)))
      |=> faultOut);

  // R10: the fault is latched while charging stays permitted
  assert_fault_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    (faultOut && chargeOk) |=> faultOut);

endmodule

// File: rtl/charge_sequencer.sv
module charge_sequencer
  import charge_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 8,
  parameter int TIMER_TICKS = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       battBelowPre,
  input  logic       battBelowRecharge,
  input  logic       battAtReg,
  input  logic       currBelowTerm,
  input  logic       therm1InWindow,
  input  logic       therm2InWindow,
  input  logic       junctionHot,
  input  logic       enableN,
  input  logic       otgPin,
  input  logic [1:0] modeSel,
  output logic [1:0] phase,
  output logic       charging,
  output logic       chargeDone,
  output logic       suspended,
  output logic       boostEn,
  output logic       foldbackReq,
  output logic       faultOut
);

  logic [FLAG_COUNT-1:0] rawFlags;
  timerCtl_t             timerCtl;
  senseBus_t             sense;

  always_comb begin
    rawFlags                = '0;
    rawFlags[FL_BELOW_PRE]  = battBelowPre;
    rawFlags[FL_BELOW_RECH] = battBelowRecharge;
    rawFlags[FL_AT_REG]     = battAtReg;
    rawFlags[FL_BELOW_TERM] = currBelowTerm;
    rawFlags[FL_TS1_OK]     = therm1InWindow;
    rawFlags[FL_TS2_OK]     = therm2InWindow;
    rawFlags[FL_HOT]        = junctionHot;
  end

  charge_seq_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYCLES (DEB_CYCLES),
    .TIMER_TICKS(TIMER_TICKS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .rawFlags(rawFlags),
    .timerCtl(timerCtl),
    .sense   (sense)
  );

  charge_seq_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .enableN    (enableN),
    .otgPin     (otgPin),
    .modeSel    (modeSel),
    .sense      (sense),
    .timerCtl   (timerCtl),
    .phase      (phase),
    .charging   (charging),
    .chargeDone (chargeDone),
    .suspended  (suspended),
    .boostEn    (boostEn),
    .foldbackReq(foldbackReq),
    .faultOut   (faultOut)
  );

endmodule

// File: tb/test_charge_sequencer.sv
`timescale 1ns/1ps
module test_charge_sequencer;

  localparam int DEB    = 4;
  localparam int TICKS  = 300;
  localparam int SETTLE = 14;

  logic clk = 1'b0;
  logic rstN;
  logic battBelowPre, battBelowRecharge, battAtReg, currBelowTerm;
  logic therm1InWindow, therm2InWindow, junctionHot;
  logic enableN, otgPin;
  logic [1:0] modeSel;
  logic [1:0] phase;
  logic charging, chargeDone, suspended, boostEn, foldbackReq, faultOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  charge_sequencer #(
    .SYNC_STAGES(2),
    .DEB_CYCLES (DEB),
    .TIMER_TICKS(TICKS)
  ) i_charge_sequencer (
    .clk(clk), .rstN(rstN),
    .battBelowPre(battBelowPre), .battBelowRecharge(battBelowRecharge),
    .battAtReg(battAtReg), .currBelowTerm(currBelowTerm),
    .therm1InWindow(therm1InWindow), .therm2InWindow(therm2InWindow),
    .junctionHot(junctionHot), .enableN(enableN), .otgPin(otgPin),
    .modeSel(modeSel), .phase(phase), .charging(charging),
    .chargeDone(chargeDone), .suspended(suspended), .boostEn(boostEn),
    .foldbackReq(foldbackReq), .faultOut(faultOut)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reenable();
    enableN = 1'b1; cyc(2);
    enableN = 1'b0; cyc(2);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 charging", charging, 0);
    chk("R1 done", chargeDone, 0);
    chk("R1 suspended", suspended, 0);
    chk("R1 foldback", foldbackReq, 0);
    chk("R1 fault", faultOut, 0);
    chk("R8 boost idle", boostEn, 0);
  endtask

  task automatic t_fullCycle();
    battBelowPre = 1'b1; cyc(SETTLE);
    enableN = 1'b0; cyc(2);
    chk("R2 start precharge", phase, 1);
    chk("R2 charging", charging, 1);
    battBelowPre = 1'b0; cyc(SETTLE);
    chk("R3 pre to cc", phase, 2);
    battAtReg = 1'b1; cyc(SETTLE);
    chk("R3 cc to cv", phase, 3);
    currBelowTerm = 1'b1; cyc(SETTLE);
    chk("R4 done flag", chargeDone, 1);
    chk("R4 charging off", charging, 0);
    chk("R4 phase none", phase, 0);
    battAtReg = 1'b0; currBelowTerm = 1'b0; cyc(SETTLE);
    chk("R5 done holds", chargeDone, 1);
    battBelowRecharge = 1'b1; cyc(SETTLE);
    chk("R5 restart cc", phase, 2);
    chk("R5 done cleared", chargeDone, 0);
    battBelowRecharge = 1'b0; cyc(SETTLE);
  endtask

  task automatic t_disable();
    enableN = 1'b1; cyc(1);
    chk("R7 enable pin idle", phase, 0);
    chk("R7 charging off", charging, 0);
    enableN = 1'b0; cyc(2);
    chk("R2 start cc", phase, 2);
    modeSel = 2'b00; cyc(1);
    chk("R7 mode field idle", phase, 0);
    modeSel = 2'b01; cyc(2);
    chk("R7 back in cc", phase, 2);
  endtask

  task automatic t_suspend();
    therm2InWindow = 1'b0; cyc(SETTLE);
    chk("R6 suspended ts2", suspended, 1);
    chk("R6 charging off", charging, 0);
    chk("R6 phase held", phase, 2);
    battAtReg = 1'b1; cyc(SETTLE);
    chk("R6 no advance while suspended", phase, 2);
    battAtReg = 1'b0; cyc(SETTLE);
    therm2InWindow = 1'b1; cyc(SETTLE);
    chk("R6 resume", charging, 1);
    chk("R6 suspend cleared", suspended, 0);
    therm1InWindow = 1'b0; cyc(SETTLE);
    chk("R6 suspended ts1", suspended, 1);
    therm1InWindow = 1'b1; cyc(SETTLE);
    chk("R6 resume ts1", charging, 1);
  endtask

  task automatic t_foldback();
    junctionHot = 1'b1; cyc(SETTLE);
    chk("R9 foldback set", foldbackReq, 1);
    chk("R9 phase kept", phase, 2);
    chk("R9 still charging", charging, 1);
    junctionHot = 1'b0; cyc(SETTLE);
    chk("R9 foldback clear", foldbackReq, 0);
  endtask

  task automatic t_glitch();
    battAtReg = 1'b1; cyc(2);
    battAtReg = 1'b0; cyc(SETTLE);
    chk("R11 short pulse ignored", phase, 2);
  endtask

  task automatic t_boost();
    modeSel = 2'b10; otgPin = 1'b1; cyc(2);
    chk("R8 boost on", boostEn, 1);
    chk("R8 charging off", charging, 0);
    chk("R8 phase none", phase, 0);
    otgPin = 1'b0; cyc(1);
    chk("R8 boost needs pin", boostEn, 0);
    modeSel = 2'b01; cyc(2);
    chk("R8 charge resumes", phase, 2);
  endtask

  task automatic t_timer();
    reenable();
    cyc(240);
    chk("R10 no early fault", faultOut, 0);
    chk("R10 still cc", phase, 2);
    cyc(80);
    chk("R10 fault set", faultOut, 1);
    chk("R10 charging off", charging, 0);
    battBelowRecharge = 1'b1; cyc(40);
    chk("R10 fault latched", faultOut, 1);
    battBelowRecharge = 1'b0; cyc(SETTLE);
    reenable();
    chk("R10 fault cleared", faultOut, 0);
    chk("R10 cycle restarts", phase, 2);
  endtask

  initial begin
    rstN = 1'b0;
    battBelowPre = 1'b0; battBelowRecharge = 1'b0; battAtReg = 1'b0;
    currBelowTerm = 1'b0; therm1InWindow = 1'b1; therm2InWindow = 1'b1;
    junctionHot = 1'b0; enableN = 1'b1; otgPin = 1'b0; modeSel = 2'b01;
    cyc(5);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    cyc(SETTLE);
    t_fullCycle();
    t_disable();
    t_suspend();
    t_foldback();
    t_glitch();
    t_boost();
    t_timer();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

endmodule